// File: doc/BRIEF.md
# External Interrupt Trigger Detector

This block sits between eight external interrupt pins and the request logic of an interrupt controller. Pin `i` feeds controller group 23+`i`. Every pin is brought into the clock domain through two flops. The block then checks the synchronized value against a per-pin trigger mode, which selects active-low level, active-high level, rising edge or falling edge. When the condition is met, the block issues a one-cycle request-set pulse on the bit of `req_set_o` that belongs to that pin.

The trigger modes are kept in two byte-wide configuration registers. Each register packs four 2-bit fields, and software reads and writes them through a small register port. The controller holds its request bits as sticky state and clears them itself. This block therefore only ever sets requests. In a level mode it repeats the set pulse on every cycle that the pin stays active, and it never withdraws a request when the pin goes idle.

Top module: `xirq_trigger`

## Requirements
- R1: Configuration byte at offset 0 holds the modes of pins 0..3 and offset 1 holds pins 4..7. Pin k of a byte uses bits [2k+1:2k]. Bit i of `req_set_o` belongs to pin i (group 23+i).
- R2: After reset every mode field is 3 (falling edge), both bytes read 8'hFF, and `req_set_o` is all zero.
- R3: Offsets 0 and 1 read back the last byte written there. Offsets 2 and 3 read 8'h00, and writes to them change no mode.
- R4: Mode 0 (active low): a set pulse is issued on every cycle that the synchronized pin is 0.
- R5: Mode 1 (active high): a set pulse is issued on every cycle that the synchronized pin is 1.
- R6: Mode 2 (rising edge): each 0-to-1 transition of the synchronized pin gives exactly one single-cycle pulse.
- R7: Mode 3 (falling edge): each 1-to-0 transition of the synchronized pin gives exactly one single-cycle pulse.
- R8: In a level mode, no pulse is issued while the pin is at its inactive level, and a return to the inactive level issues nothing.
- R9: A change of mode while the pin holds steady produces no pulse of its own. The edge baseline is always the previously synchronized sample.
- R10: A pin value sampled at clock edge n takes effect on `req_set_o` just after edge n+2. The mode used is the one in force after edge n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` (combinational) |
| req_set_o | output | NUM_PINS | One-cycle request-set pulses, one per pin |

## Verification
The assertions check the following on every cycle, pin by pin:
- a level mode with an active synchronized pin is followed by a pulse, and an inactive pin by none;
- an edge-mode pulse never lasts two cycles while the mode is unchanged;
- an edge mode with a steady synchronized pin gives no pulse;
- out-of-range offsets read zero and leave the modes untouched.

Some behaviour only the bench scenarios can show. These are the exact three-edge latency from the pin, the mapping of packed fields onto output bits, and the reset readback of 8'hFF. They also include the absence of pulses across mid-stream mode rewrites, checked while the pins toggle randomly.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LO = 2'd0,
    TRIG_LVL_HI = 2'd1,
    TRIG_RISE   = 2'd2,
    TRIG_FALL   = 2'd3
  } trig_mode_e;

  localparam int MODE_W     = 2;
  localparam int FIELDS_PER = 8 / MODE_W;

  // Decide whether a pin condition is met for one mode.
  function automatic logic trig_fire(trig_mode_e m, logic now_s, logic last_s);
    logic fire;
    unique case (m)
      TRIG_LVL_LO: fire = ~now_s;
      TRIG_LVL_HI: fire = now_s;
      TRIG_RISE:   fire = now_s & ~last_s;
      TRIG_FALL:   fire = ~now_s & last_s;
      default:     fire = 1'b0;
    endcase
    return fire;
  endfunction

  // Pull field k out of a packed configuration byte.
  function automatic logic [MODE_W-1:0] field_of(logic [7:0] b, int unsigned k);
    return b[MODE_W*k +: MODE_W];
  endfunction

endpackage

// File: rtl/xirq_sync2.sv
module xirq_sync2 #(
  parameter int   WIDTH   = 8,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= {WIDTH{RST_VAL}};
      stage2_q <= {WIDTH{RST_VAL}};
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;

endmodule

// File: rtl/xirq_mode_regs.sv
module xirq_mode_regs
  import xirq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [ADDR_W-1:0]              cfg_addr,
  input  logic [7:0]                     cfg_wdata,
  output logic [7:0]                     cfg_rdata,
  output logic [NUM_PINS-1:0][MODE_W-1:0] mode_o
);

  localparam int NUM_BYTES = (NUM_PINS + FIELDS_PER - 1) / FIELDS_PER;

  logic [NUM_BYTES-1:0][7:0] cfg_q;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[b] <= 8'hFF;  // every field = falling edge
      else if (cfg_we && cfg_addr == ADDR_W'(b))
        cfg_q[b] <= cfg_wdata;
    end
  end

  always_comb begin
    cfg_rdata = 8'h00;
    for (int b = 0; b < NUM_BYTES; b++)
      if (cfg_addr == ADDR_W'(b)) cfg_rdata = cfg_q[b];
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_field
    assign mode_o[i] = field_of(cfg_q[i / FIELDS_PER], i % FIELDS_PER);
  end

endmodule

// File: rtl/xirq_lane.sv
module xirq_lane
  import xirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              req_o
);

  logic last_q;
  logic fire;

  // Baseline always follows the synchronized pin, whatever the mode.
  assign fire = trig_fire(trig_mode_e'(mode_i), sync_i, last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b1;
      req_o  <= 1'b0;
    end else begin
      last_q <= sync_i;
      req_o  <= fire;
    end
  end

endmodule

// File: rtl/xirq_trigger.sv
module xirq_trigger
  import xirq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [7:0]          cfg_wdata,
  output logic [7:0]          cfg_rdata,
  output logic [NUM_PINS-1:0] req_set_o
);

  logic [NUM_PINS-1:0]             sync_vec;
  logic [NUM_PINS-1:0][MODE_W-1:0] mode_vec;

  xirq_sync2 #(.WIDTH(NUM_PINS), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (sync_vec)
  );

  xirq_mode_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .mode_o    (mode_vec)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
    xirq_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_i (sync_vec[i]),
      .mode_i (mode_vec[i]),
      .req_o  (req_set_o[i])
    );
  end

endmodule

// File: rtl/xirq_trigger_chk.sv
module xirq_trigger_chk #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_PINS-1:0]       sync_vec,
  input logic [NUM_PINS-1:0][1:0]  mode_vec,
  input logic [NUM_PINS-1:0]       req,
  input logic                      cfg_we,
  input logic [ADDR_W-1:0]         cfg_addr,
  input logic [7:0]                cfg_rdata
);

  localparam int NUM_BYTES = (NUM_PINS + 3) / 4;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    p_lvl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vec[i] == 2'd0 && !sync_vec[i]) |=> req[i]);

    p_lvl_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vec[i] == 2'd1 && sync_vec[i]) |=> req[i]);

    p_lvl_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_vec[i][1] && sync_vec[i] != mode_vec[i][0]) |=> !req[i]);

    p_edge_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req[i] && mode_vec[i][1] && $stable(mode_vec[i])) |=> !req[i]);

    p_edge_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vec[i][1] && $stable(sync_vec[i])) |=> !req[i]);
  end

  p_oob_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr >= ADDR_W'(NUM_BYTES)) |-> cfg_rdata == 8'h00);

  p_oob_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr >= ADDR_W'(NUM_BYTES)) |=> $stable(mode_vec));

endmodule

bind xirq_trigger xirq_trigger_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync_vec  (sync_vec),
  .mode_vec  (mode_vec),
  .req       (req_set_o),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata)
);

// File: tb/sim_xirq_trigger.sv
`timescale 1ns/1ps
module sim_xirq_trigger;
  localparam int NP = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '1;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = 8'h00;
  logic [7:0]    rdata;
  logic [NP-1:0] req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit track = 1'b0;

  always #2.5 clk = ~clk;

  xirq_trigger #(.NUM_PINS(NP), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .cfg_we(we), .cfg_addr(addr),
    .cfg_wdata(wdata), .cfg_rdata(rdata), .req_set_o(req)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: does a pin with mode md and samples (now, before) request?
  function automatic bit ref_fire(logic [1:0] md, logic now_v, logic before_v);
    if (md[1] == 1'b0) return (now_v == md[0]);
    if (md[0] == 1'b0) return (now_v && !before_v);
    return (!now_v && before_v);
  endfunction

  // Bench shadow of the configuration and a pin sample history.
  logic [7:0]    shadow [2] = '{8'hFF, 8'hFF};
  logic [NP-1:0] h1 = '1, h2 = '1, h3 = '1;
  logic [NP-1:0] exp_req = '0;
  logic [1:0]    md_used [NP];

  // R10: output after edge m uses the mode after edge m-1 and samples m-2, m-3.
  always @(posedge clk) begin
    if (track) begin
      for (int i = 0; i < NP; i++) begin
        md_used[i] = shadow[i/4][2*(i%4) +: 2];
        exp_req[i] = ref_fire(md_used[i], h2[i], h3[i]);
      end
      h3 = h2; h2 = h1; h1 = pins;
      if (we && addr < 2'd2) shadow[addr[0]] = wdata;
    end
  end

  always @(negedge clk) begin
    if (track) begin
      for (int i = 0; i < NP; i++) begin
        string tg;
        case (md_used[i])
          2'd0: tg = "R4 active-low";
          2'd1: tg = "R5 active-high";
          2'd2: tg = "R6 rising";
          default: tg = "R7 falling";
        endcase
        check(req[i] == exp_req[i], $sformatf("%s pin %0d", tg, i), req[i], exp_req[i]);
      end
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(logic [AW-1:0] a, logic [7:0] e, string tag);
    @(negedge clk); addr = a; #1;
    check(rdata == e, tag, rdata, e);
  endtask

  task automatic wait_pos(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // R2: reset state
    repeat (3) @(negedge clk);
    check(req == '0, "R2 reset req", req, 0);
    addr = 2'd0; #1; check(rdata == 8'hFF, "R2 reset byte0", rdata, 8'hFF);
    addr = 2'd1; #1; check(rdata == 8'hFF, "R2 reset byte1", rdata, 8'hFF);
    @(negedge clk); rst_n = 1'b1; track = 1'b1;

    // R1: field layout (pin0 lo, pin1 hi, pin2 rise, pin3 fall / pin4 fall, pin5 rise, pin6 hi, pin7 lo)
    wr(2'd0, 8'hE4);
    wr(2'd1, 8'h1B);
    rd_chk(2'd0, 8'hE4, "R1 byte0 readback");
    rd_chk(2'd1, 8'h1B, "R1 byte1 readback");
    // R3: out-of-range offsets
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h55);
    rd_chk(2'd2, 8'h00, "R3 offset2 reads zero");
    rd_chk(2'd3, 8'h00, "R3 offset3 reads zero");
    rd_chk(2'd0, 8'hE4, "R3 byte0 untouched");
    rd_chk(2'd1, 8'h1B, "R3 byte1 untouched");
    wait_pos(4);

    // R10 latency and R1 bit mapping: pin0 low
    @(negedge clk); pins[0] = 1'b0;
    wait_pos(2); @(negedge clk);
    check(req == 8'h42, "R10 not yet after two edges", req, 8'h42);
    @(negedge clk);
    check(req == 8'h43, "R10/R1 pulse after three edges", req, 8'h43);
    @(negedge clk);
    check(req[0] == 1'b1, "R4 repeats while low", req[0], 1);

    // R8: return to inactive level gives nothing
    pins[0] = 1'b1;
    wait_pos(3);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(req[0] == 1'b0, "R8 idle level no pulse", req[0], 0);
    end

    // R9: swap edge modes of pins 2/3 with pins steady
    wr(2'd0, 8'hB4);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(req[3:2] == 2'b00, "R9 mode change no pulse", req[3:2], 0);
    end
    pins[2] = 1'b0;  // pin2 now falling: exactly one pulse
    wait_pos(3); @(negedge clk);
    check(req[2] == 1'b1, "R7 falling pulse", req[2], 1);
    @(negedge clk);
    check(req[2] == 1'b0, "R7 single cycle", req[2], 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      pins = pins ^ NP'($urandom & $urandom & $urandom);
      if (($urandom % 16) == 0) begin
        we = 1'b1; addr = AW'($urandom); wdata = 8'($urandom);
      end else begin
        we = 1'b0; addr = AW'($urandom);
      end
    end
    @(negedge clk); we = 1'b0;
    wait_pos(5); @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule